// File: doc/BRIEF.md
# AC-Link Frame Formatter

This block builds and takes apart the bit-level framing of a serial codec link. The link uses a fixed 256-bit frame. A 16-bit tag slot comes first, then twelve data slots of 20 bits each. Running on the link bit clock, the block drives the frame sync pulse and the serial output. It also keeps a bit position (0 to 255) and a slot index (0 to 12), and it turns serial slot data into 16-bit words and back. On the transmit side it takes one word at a time from a word input and pulses a take strobe. On the receive side it presents each finished word with a one-cycle valid strobe.

A two-bit mode input selects the packing. In aligned mode (10), every slot maps to exactly one word. A data slot sends the word followed by four zero bits, and on receive the low four bits of a data slot are discarded. In streaming mode (11), all 20 bits of every data slot are used. The whole frame then behaves as an unbroken run of 16-bit words that crosses slot boundaries. Both other mode codes stop the link. The tag slot always holds one whole word in both packing modes.

Top module: `acl_frame_fmt`

## Requirements
- R1: While the link runs, `bit_pos` advances by one on every bit clock, from 0 to 255, and then wraps to 0.
- R2: `frame_sync` is high while `bit_pos` is 0 to 15 and low while it is 16 to 255; it rises with bit 0 of the frame.
- R3: `slot_idx` is 0 for positions 0 to 15 and 1+(p-16)/20 for a position p from 16 to 255, so it reaches 12 in the last slot.
- R4: Mode 10 selects aligned packing and mode 11 selects streaming. With mode bit 1 low (00 or 01), the next rising edge drives `frame_sync`, `sdo`, `tx_take`, `rx_valid`, `bit_pos` and `slot_idx` to 0 and halts the link. When a valid mode returns, position 0 appears after the second rising edge.
- R5: Serial data goes out MSB first. The tag slot (positions 0 to 15) carries one whole word in both modes.
- R6: In aligned mode, each data slot carries one word in its first 16 bits, followed by 4 zero bits. A frame uses 13 words.
- R7: In streaming mode, a frame carries 16 words back to back. Word k occupies positions 16k to 16k+15, regardless of slot boundaries.
- R8: `tx_take` is high for exactly the bit period that shows a word's MSB. `tx_word` is captured at the rising edge that starts that period.
- R9: `sdi` is sampled on the falling bit clock edge. In aligned mode, a received word is the tag slot, or the first 16 bits of a data slot, MSB first. The last 4 bits of a data slot are dropped.
- R10: In streaming mode, every 16 consecutive frame bits starting at position 0 form one received word.
- R11: `rx_valid` is a one-cycle pulse in the bit period right after a word's last bit, and `rx_word` holds that word during the pulse.
- R12: A frame's packing mode is the mode value at the rising edge that drives position 255 of the frame before it. A change between 10 and 11 in mid-frame does not alter the frame in progress.
- R13: Under reset, all outputs are 0. After reset is released, position 0 of the first frame appears after the second rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link bit clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 10 aligned, 11 streaming, 0x stopped |
| tx_word | input | 16 | Next word to transmit |
| tx_take | output | 1 | Word on `tx_word` was captured; its MSB is on `sdo` |
| sdi | input | 1 | Serial data in, sampled on the falling edge |
| sdo | output | 1 | Serial data out, changes on the rising edge |
| frame_sync | output | 1 | Frame sync, high for the tag slot |
| rx_word | output | 16 | Last received word |
| rx_valid | output | 1 | One-cycle strobe for `rx_word` |
| bit_pos | output | 8 | Position of the bit on `sdo` |
| slot_idx | output | 4 | Slot of the bit on `sdo` |

## Verification
The transmit capture of a new word and the receive completion of the previous word can land in the same rising edge. In the tag slot and in streaming mode, the last bit of one word is directly followed by the MSB of the next. So in one bit period `tx_take` and `rx_valid` are both high, and `sdo` must already show the new MSB. The bench triggers this in every frame of both modes. It drives an independent pseudo-random pattern on `sdi`, so the receive words never match the transmit words. In each such period it judges `tx_take`, `sdo`, `rx_valid` and `rx_word` separately against its own positional model. Mode changes at position 100, and stops with a receive word pending, check that the frame in progress is not disturbed.

// File: rtl/acl_pkg.sv
`timescale 1ns/1ps
package acl_pkg;
    localparam int TAG_W   = 16;
    localparam int SLOT_W  = 20;
    localparam int N_DATA  = 12;
    localparam int WORD_W  = 16;
    localparam int FRAME_W = TAG_W + N_DATA * SLOT_W;
    localparam int POS_W   = $clog2(FRAME_W);
    localparam int SLOT_IW = $clog2(N_DATA + 1);
    localparam int OFF_W   = $clog2(SLOT_W);
    localparam int WB      = $clog2(WORD_W);

    typedef enum logic [1:0] {
        MODE_STOP0    = 2'b00,
        MODE_STOP1    = 2'b01,
        MODE_ALIGN16  = 2'b10,
        MODE_STREAM20 = 2'b11
    } mode_e;

    typedef struct packed {
        logic               active;
        logic               stream;
        logic [POS_W-1:0]   pos;
        logic [SLOT_IW-1:0] slot;
        logic [OFF_W-1:0]   off;
    } lpos_t;

    function automatic logic word_first(lpos_t p);
        if (!p.active) return 1'b0;
        if (p.stream)  return p.pos[WB-1:0] == '0;
        return p.off == '0;
    endfunction

    function automatic logic word_last(lpos_t p);
        if (!p.active) return 1'b0;
        if (p.stream)  return p.pos[WB-1:0] == WB'(WORD_W - 1);
        return p.off == OFF_W'(WORD_W - 1);
    endfunction

    function automatic logic pad_bit(lpos_t p);
        return p.active && !p.stream && (p.slot != '0) && (p.off >= OFF_W'(WORD_W));
    endfunction
endpackage

// File: rtl/acl_counter.sv
`timescale 1ns/1ps
module acl_counter
    import acl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode,
    output lpos_t      cnt
);
    logic slot_end;
    logic frame_end;

    always_comb begin
        if (cnt.slot == '0) slot_end = (cnt.off == OFF_W'(TAG_W - 1));
        else                slot_end = (cnt.off == OFF_W'(SLOT_W - 1));
        frame_end = (cnt.pos == POS_W'(FRAME_W - 1));
    end

    always_ff @(posedge clk) begin
        if (rst || !mode[1]) begin
            cnt <= '0;
        end else if (!cnt.active) begin
            cnt.active <= 1'b1;
            cnt.stream <= mode[0];
            cnt.pos    <= '0;
            cnt.slot   <= '0;
            cnt.off    <= '0;
        end else begin
            if (frame_end) begin
                cnt.pos    <= '0;
                cnt.stream <= mode[0];
            end else begin
                cnt.pos <= cnt.pos + POS_W'(1);
            end
            if (slot_end) begin
                cnt.off  <= '0;
                cnt.slot <= (cnt.slot == SLOT_IW'(N_DATA)) ? '0 : cnt.slot + SLOT_IW'(1);
            end else begin
                cnt.off <= cnt.off + OFF_W'(1);
            end
        end
    end
endmodule

// File: rtl/acl_tx.sv
`timescale 1ns/1ps
module acl_tx
    import acl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              link_on,
    input  lpos_t             cur,
    input  logic [WORD_W-1:0] tx_word,
    output logic              sdo,
    output logic              take
);
    logic [WORD_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst || !link_on) begin
            sdo   <= 1'b0;
            take  <= 1'b0;
            shreg <= '0;
        end else if (word_first(cur)) begin
            sdo   <= tx_word[WORD_W-1];
            shreg <= {tx_word[WORD_W-2:0], 1'b0};
            take  <= 1'b1;
        end else begin
            take <= 1'b0;
            if (pad_bit(cur)) begin
                sdo <= 1'b0;
            end else begin
                sdo   <= shreg[WORD_W-1];
                shreg <= {shreg[WORD_W-2:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/acl_rx.sv
`timescale 1ns/1ps
module acl_rx
    import acl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              link_on,
    input  lpos_t             wire_pos,
    input  logic              sdi,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid
);
    logic              sdi_fall;
    logic [WORD_W-1:0] shreg;

    always_ff @(negedge clk) begin
        sdi_fall <= sdi;
    end

    always_ff @(posedge clk) begin
        if (rst || !link_on) begin
            shreg    <= '0;
            rx_word  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (wire_pos.active && !pad_bit(wire_pos)) begin
                shreg <= {shreg[WORD_W-2:0], sdi_fall};
                if (word_last(wire_pos)) begin
                    rx_word  <= {shreg[WORD_W-2:0], sdi_fall};
                    rx_valid <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/acl_frame_fmt.sv
`timescale 1ns/1ps
module acl_frame_fmt
    import acl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         mode,
    input  logic [WORD_W-1:0]  tx_word,
    output logic               tx_take,
    input  logic               sdi,
    output logic               sdo,
    output logic               frame_sync,
    output logic [WORD_W-1:0]  rx_word,
    output logic               rx_valid,
    output logic [POS_W-1:0]   bit_pos,
    output logic [SLOT_IW-1:0] slot_idx
);
    lpos_t cnt;
    lpos_t wire_pos;

    acl_counter u_counter (
        .clk  (clk),
        .rst  (rst),
        .mode (mode),
        .cnt  (cnt)
    );

    always_ff @(posedge clk) begin
        if (rst || !mode[1]) wire_pos <= '0;
        else                 wire_pos <= cnt;
    end

    acl_tx u_tx (
        .clk     (clk),
        .rst     (rst),
        .link_on (mode[1]),
        .cur     (cnt),
        .tx_word (tx_word),
        .sdo     (sdo),
        .take    (tx_take)
    );

    acl_rx u_rx (
        .clk      (clk),
        .rst      (rst),
        .link_on  (mode[1]),
        .wire_pos (wire_pos),
        .sdi      (sdi),
        .rx_word  (rx_word),
        .rx_valid (rx_valid)
    );

    assign frame_sync = wire_pos.active && (wire_pos.pos < POS_W'(TAG_W));
    assign bit_pos    = wire_pos.pos;
    assign slot_idx   = wire_pos.slot;
endmodule

// File: rtl/acl_frame_chk.sv
`timescale 1ns/1ps
module acl_frame_chk
    import acl_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               link_on,
    input logic               frame_sync,
    input logic               sdo,
    input logic               tx_take,
    input logic               rx_valid,
    input logic [POS_W-1:0]   bit_pos,
    input logic [SLOT_IW-1:0] slot_idx
);
    assert_pos_step_R1: assert property (@(posedge clk) disable iff (rst)
        (link_on && (frame_sync || bit_pos != '0) && bit_pos != POS_W'(FRAME_W - 1))
        |=> (!link_on || bit_pos == $past(bit_pos) + POS_W'(1)));

    assert_sync_fall_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(frame_sync) |-> (bit_pos == POS_W'(TAG_W) || bit_pos == '0));

    assert_sync_rise_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_sync) |-> (bit_pos == '0 && slot_idx == '0));

    assert_first_slot_R3: assert property (@(posedge clk) disable iff (rst)
        (!$stable(slot_idx) && slot_idx == SLOT_IW'(1)) |-> bit_pos == POS_W'(TAG_W));

    assert_stop_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        !link_on |=> (!frame_sync && !sdo && !tx_take && !rx_valid));

    assert_take_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        tx_take |=> !tx_take);

    assert_valid_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);
endmodule

bind acl_frame_fmt acl_frame_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .link_on    (mode[1]),
    .frame_sync (frame_sync),
    .sdo        (sdo),
    .tx_take    (tx_take),
    .rx_valid   (rx_valid),
    .bit_pos    (bit_pos),
    .slot_idx   (slot_idx)
);

// File: tb/test_acl_frame_fmt.sv
`timescale 1ns/1ps
module test_acl_frame_fmt;
    localparam int IDLE = -1000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode = 2'b10;
    logic [15:0] tx_word;
    logic        tx_take;
    logic        sdi = 1'b0;
    logic        sdo;
    logic        frame_sync;
    logic [15:0] rx_word;
    logic        rx_valid;
    logic [7:0]  bit_pos;
    logic [3:0]  slot_idx;

    int   nchk = 0;
    int   nerr = 0;
    int   exp_pos = IDLE;
    int   nt = 0;
    bit   fstream = 1'b0;
    logic [15:0] cur_word = '0;
    logic [15:0] bsh = '0;
    logic [15:0] lfsr = 16'hACE1;
    bit          pend_valid = 1'b0;
    logic [15:0] pend_word = '0;
    bit          pend_stream = 1'b0;

    always #2 clk = ~clk;

    acl_frame_fmt i_acl_frame_fmt (
        .clk(clk), .rst(rst), .mode(mode), .tx_word(tx_word), .tx_take(tx_take),
        .sdi(sdi), .sdo(sdo), .frame_sync(frame_sync), .rx_word(rx_word),
        .rx_valid(rx_valid), .bit_pos(bit_pos), .slot_idx(slot_idx)
    );

    function automatic logic [15:0] wgen(int n);
        return 16'(n * 40503 + 4660) ^ 16'(n << 3);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s at pos %0d: actual=%0h expected=%0h", req, exp_pos, act, expv);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
    endtask

    task automatic tick();
        int p;
        int b;
        int o;
        bit pad;
        bit exp_take;
        bit exp_sdo;
        bit rbit;
        int eslot;
        @(posedge clk);
        #1;
        if (exp_pos != IDLE) begin
            exp_pos++;
            if (exp_pos == 256) exp_pos = 0;
        end
        p = exp_pos;
        // R11: strobe one period after the last bit of a word
        chk(rx_valid == pend_valid, "R11 rx_valid", int'(rx_valid), int'(pend_valid));
        if (pend_valid) begin
            if (pend_stream)
                chk(rx_word == pend_word, "R10 rx_word stream", int'(rx_word), int'(pend_word));
            else
                chk(rx_word == pend_word, "R9 rx_word aligned", int'(rx_word), int'(pend_word));
        end
        pend_valid = 1'b0;
        rbit = lfsr[0];
        lfsr = lfsr[0] ? ((lfsr >> 1) ^ 16'hB400) : (lfsr >> 1);
        sdi = rbit;
        if (p < 0) begin
            // R13 / R4: quiet outputs while stopped or starting
            chk(frame_sync == 1'b0, "R13 sync idle", int'(frame_sync), 0);
            chk(sdo == 1'b0, "R13 sdo idle", int'(sdo), 0);
            chk(tx_take == 1'b0, "R4 take idle", int'(tx_take), 0);
            chk(bit_pos == 8'd0 && slot_idx == 4'd0, "R4 pos idle", int'(bit_pos), 0);
        end else begin
            if (p == 0) fstream = mode[0];  // R12
            eslot = (p < 16) ? 0 : 1 + (p - 16) / 20;
            chk(bit_pos == 8'(p), "R1 bit_pos", int'(bit_pos), p);
            chk(frame_sync == (p < 16), "R2 frame_sync", int'(frame_sync), int'(p < 16));
            chk(slot_idx == 4'(eslot), "R3 slot_idx", int'(slot_idx), eslot);
            pad = 1'b0;
            if (fstream) b = p % 16;
            else if (p < 16) b = p;
            else begin
                o = (p - 16) % 20;
                pad = (o >= 16);
                b = o;
            end
            exp_take = !pad && (b == 0);
            chk(tx_take == exp_take, "R8 tx_take", int'(tx_take), int'(exp_take));
            if (exp_take) cur_word = tx_word;
            if (pad) begin
                exp_sdo = 1'b0;
                chk(sdo == exp_sdo, "R6 zero pad", int'(sdo), 0);
            end else begin
                exp_sdo = cur_word[15 - b];
                if (p < 16)
                    chk(sdo == exp_sdo, "R5 tag bit", int'(sdo), int'(exp_sdo));
                else if (fstream)
                    chk(sdo == exp_sdo, "R7 stream bit", int'(sdo), int'(exp_sdo));
                else
                    chk(sdo == exp_sdo, "R6 aligned bit", int'(sdo), int'(exp_sdo));
                bsh = {bsh[14:0], rbit};
                if (b == 15) begin
                    pend_valid  = 1'b1;
                    pend_word   = bsh;
                    pend_stream = fstream;
                end
            end
        end
        if (tx_take) begin
            nt++;
            tx_word = wgen(nt);
        end
    endtask

    task automatic run_to(int target);
        tick();
        while (exp_pos != target) tick();
    endtask

    task automatic run_frames(int nf);
        for (int f = 0; f < nf; f++) run_to(255);
    endtask

    task automatic stop_link(logic [1:0] m, int cycles);
        mode = m;
        exp_pos = IDLE;
        pend_valid = 1'b0;
        for (int i = 0; i < cycles; i++) tick();
    endtask

    task automatic start_link(logic [1:0] m);
        mode = m;
        exp_pos = -2;
    endtask

    initial begin
        #(200000 * 4);
        nerr++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    initial begin
        tx_word = wgen(0);
        // R13: reset state
        for (int i = 0; i < 5; i++) tick();
        rst = 1'b0;
        exp_pos = -2;
        // aligned packing: R5 R6 R9
        run_frames(3);
        // R12: switch to streaming in mid-frame
        run_to(100);
        mode = 2'b11;
        run_to(255);
        run_frames(3);
        // back to aligned in mid-frame
        run_to(100);
        mode = 2'b10;
        run_to(255);
        run_frames(2);
        // R4: stop with code 00, restart in streaming
        run_to(100);
        stop_link(2'b00, 40);
        start_link(2'b11);
        run_frames(2);
        // R4: stop with code 01 right after a word end, restart aligned
        run_to(15);
        stop_link(2'b01, 30);
        start_link(2'b10);
        run_frames(2);
        summary();
        $finish;
    end
endmodule